// File: doc/BRIEF.md
# Laser Bias Fault Supervisor

This block guards a laser bias current source. Every system clock it examines the bias and photodiode measurements, the photodiode setpoint, the bias DAC code and two analog over-threshold comparator flags. When supervision is armed and any fault condition is seen, it removes the bias gate, raises and holds a fault pin, and sets two status bits: a sticky fault flag and a driver-off flag.

Clearing a fault takes a timed handshake. Either the disable pin is raised or the bias-enable control bit is dropped, and that request must be held for a minimum number of cycles. While it is held the fault pin goes low. When the request is released, the block checks the fault conditions again. If a fault is still present, the pin latches again. If none is present, the bias gate stays off for a negate interval and then normal operation resumes. No configuration is changed at any point.

All inputs are level signals sampled on every clock, plus one strobe that marks a new DAC code. The block has no data stream, so there is no valid/ready interface and no back-pressure.

Top module: `lbias_guard`

## Requirements
- R1: After reset, `flt_pin`, `stat_fault` and `stat_drv_off` are 0, and `bias_gate` equals `bias_en & ~dis_pin`.
- R2: While `arm` is 0, no input pattern latches a fault.
- R3: With `dig_bias_mode` = 1, a fault is raised when `bias_meas[9:2] > bias_thr`; equality is not a fault. With `dig_bias_mode` = 0, `bias_ana_hi` raises the fault instead.
- R4: With `dig_pd_mode` = 0, `pd_ana_hi` raises a fault only when `pd_trig_en` = 1. With `dig_pd_mode` = 1, a fault is raised when `pd_meas[9:2] > pd_thr`; equality is not a fault.
- R5: A fault is raised when `2*pd_meas > 3*pd_setpt`; exact equality is not a fault.
- R6: On a cycle with `dac_load` = 1, a fault is raised when `2*dac_code` is less than the code taken on the previous load (0 after reset). A drop to exactly half is not a fault.
- R7: A fault seen at a clock edge sets `flt_pin`, `stat_fault` and `stat_drv_off` to 1 and `bias_gate` to 0 from that edge onward.
- R8: When the release request (`dis_pin` | ~`bias_en`) appears, `flt_pin` is 0 from the next edge for as long as the request is held. If the request is held for fewer than `HOLD_CYC` edges, `flt_pin` returns to 1 when it ends.
- R9: After a request of at least `HOLD_CYC` edges ends with no fault present, `bias_gate` stays 0 for `NEG_CYC` cycles and then returns. `stat_fault` and `stat_drv_off` clear at that point.
- R10: If a fault is still present when a long enough request ends, `flt_pin` latches again and the bias does not resume.
- R11: Without a fault, `dis_pin` = 1 turns `bias_gate` off at once and keeps `stat_drv_off` at 0. Clearing `dis_pin` restores `bias_gate` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Enables fault supervision |
| bias_en | input | 1 | Bias enable control bit |
| dis_pin | input | 1 | External disable pin |
| dig_bias_mode | input | 1 | 1: compare the bias measurement word; 0: use the analog flag |
| dig_pd_mode | input | 1 | 1: compare the photodiode measurement word; 0: use the analog flag |
| pd_trig_en | input | 1 | Allows the analog photodiode flag to raise a fault |
| bias_thr | input | 8 | Bias fault threshold |
| pd_thr | input | 8 | Photodiode fault threshold |
| bias_meas | input | 10 | Measured bias current |
| pd_meas | input | 10 | Measured photodiode current |
| pd_setpt | input | 10 | Photodiode current setpoint |
| dac_code | input | 10 | Bias DAC code |
| dac_load | input | 1 | Strobe marking a new DAC code |
| bias_ana_hi | input | 1 | Analog bias monitor above reference |
| pd_ana_hi | input | 1 | Analog photodiode monitor above reference |
| bias_gate | output | 1 | Bias current permitted |
| flt_pin | output | 1 | Latched fault pin |
| stat_fault | output | 1 | Sticky fault status |
| stat_drv_off | output | 1 | Driver held off by the supervisor |

## Verification
Each fault source is driven exactly at its boundary and then one step past it. This covers threshold equality against threshold plus one, a photodiode reading of exactly 150% against one code above, and a DAC drop to exactly half against a deeper drop. A wrong comparison operator or a slice of the wrong bits therefore shows up. Release requests are applied in three forms: shorter than the hold time, long enough but with the fault still present, and long enough with the fault cleared. These separate the timing of the re-latch from the timing of the resume. The analog flags are also raised while their enables are off, and the disable pin is pulsed with no fault present, to show that those paths neither latch a fault nor add delay.

// File: rtl/lbg_pkg.sv
package lbg_pkg;
  typedef enum logic [1:0] {
    RS_RUN    = 2'd0,
    RS_LATCH  = 2'd1,
    RS_HOLD   = 2'd2,
    RS_RESUME = 2'd3
  } rec_state_e;
endpackage

// File: rtl/lbg_cond_eval.sv
module lbg_cond_eval #(
  parameter int MEAS_W = 10,
  parameter int THR_W  = 8
) (
  input  logic              arm,
  input  logic              dig_bias_mode,
  input  logic              dig_pd_mode,
  input  logic              pd_trig_en,
  input  logic [THR_W-1:0]  bias_thr,
  input  logic [THR_W-1:0]  pd_thr,
  input  logic [MEAS_W-1:0] bias_meas,
  input  logic [MEAS_W-1:0] pd_meas,
  input  logic [MEAS_W-1:0] pd_setpt,
  input  logic              bias_ana_hi,
  input  logic              pd_ana_hi,
  input  logic              dac_drop,
  output logic              flt_now
);
  localparam int TOP_LSB = MEAS_W - THR_W;
  localparam int PROD_W  = MEAS_W + 2;

  logic bias_hit, pd_hit, over_hit;
  logic [PROD_W-1:0] pd_x2, set_x3;

  always_comb begin
    pd_x2  = PROD_W'({pd_meas, 1'b0});
    set_x3 = PROD_W'({pd_setpt, 1'b0}) + PROD_W'(pd_setpt);
    over_hit = pd_x2 > set_x3;
    bias_hit = dig_bias_mode ? (bias_meas[MEAS_W-1:TOP_LSB] > bias_thr) : bias_ana_hi;
    pd_hit   = dig_pd_mode ? (pd_meas[MEAS_W-1:TOP_LSB] > pd_thr) : (pd_trig_en & pd_ana_hi);
    flt_now  = arm & (bias_hit | pd_hit | over_hit | dac_drop);
  end

  always_comb begin
    if (!arm) assert_disarmed_quiet_R2: assert (!flt_now);
  end
endmodule

// File: rtl/lbg_dac_watch.sv
module lbg_dac_watch #(
  parameter int MEAS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_load,
  input  logic [MEAS_W-1:0] dac_code,
  output logic              dac_drop
);
  logic [MEAS_W-1:0] prev_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_code <= '0;
    else if (dac_load) prev_code <= dac_code;
  end

  always_comb dac_drop = dac_load & ({1'b0, dac_code, 1'b0} < {2'b00, prev_code});

  assert_prev_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |=> (prev_code == $past(dac_code)));
endmodule

// File: rtl/lbg_recovery.sv
module lbg_recovery
  import lbg_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int NEG_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_now,
  input  logic rel_req,
  output logic latched,
  output logic drv_off,
  output logic sticky
);
  localparam int MAXC  = (HOLD_CYC > NEG_CYC) ? HOLD_CYC : NEG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] NEG_LIM  = CNT_W'(NEG_CYC);

  rec_state_e st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RS_RUN;
      cnt <= '0;
      sticky <= 1'b0;
    end else begin
      unique case (st)
        RS_RUN: if (flt_now) begin
          st <= RS_LATCH;
          sticky <= 1'b1;
        end
        RS_LATCH: if (rel_req) begin
          st <= RS_HOLD;
          cnt <= CNT_W'(1);
        end
        RS_HOLD: begin
          if (rel_req) begin
            if (cnt < HOLD_LIM) cnt <= cnt + 1'b1;
          end else if (cnt < HOLD_LIM) begin
            st <= RS_LATCH;
          end else if (flt_now) begin
            st <= RS_LATCH;
          end else begin
            st <= RS_RESUME;
            cnt <= CNT_W'(1);
          end
        end
        RS_RESUME: begin
          if (flt_now) st <= RS_LATCH;
          else if (cnt >= NEG_LIM) begin
            st <= RS_RUN;
            sticky <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RS_RUN;
      endcase
    end
  end

  always_comb begin
    latched = (st == RS_LATCH);
    drv_off = (st != RS_RUN);
  end

  assert_latch_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_RUN && flt_now) |=> (latched && sticky));
  assert_pin_low_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_LATCH && rel_req) |=> !latched);
  assert_short_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_HOLD && !rel_req && cnt < HOLD_LIM) |=> latched);
  assert_persist_relatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RS_HOLD && !rel_req && flt_now) |=> latched);
endmodule

// File: rtl/lbias_guard.sv
module lbias_guard #(
  parameter int MEAS_W   = 10,
  parameter int THR_W    = 8,
  parameter int HOLD_CYC = 8,
  parameter int NEG_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              bias_en,
  input  logic              dis_pin,
  input  logic              dig_bias_mode,
  input  logic              dig_pd_mode,
  input  logic              pd_trig_en,
  input  logic [THR_W-1:0]  bias_thr,
  input  logic [THR_W-1:0]  pd_thr,
  input  logic [MEAS_W-1:0] bias_meas,
  input  logic [MEAS_W-1:0] pd_meas,
  input  logic [MEAS_W-1:0] pd_setpt,
  input  logic [MEAS_W-1:0] dac_code,
  input  logic              dac_load,
  input  logic              bias_ana_hi,
  input  logic              pd_ana_hi,
  output logic              bias_gate,
  output logic              flt_pin,
  output logic              stat_fault,
  output logic              stat_drv_off
);
  logic dac_drop, flt_now, rel_req, latched, drv_off, sticky;

  lbg_dac_watch #(.MEAS_W(MEAS_W)) u_dac (
    .clk(clk), .rst_n(rst_n), .dac_load(dac_load), .dac_code(dac_code), .dac_drop(dac_drop)
  );

  lbg_cond_eval #(.MEAS_W(MEAS_W), .THR_W(THR_W)) u_cond (
    .arm(arm), .dig_bias_mode(dig_bias_mode), .dig_pd_mode(dig_pd_mode),
    .pd_trig_en(pd_trig_en), .bias_thr(bias_thr), .pd_thr(pd_thr),
    .bias_meas(bias_meas), .pd_meas(pd_meas), .pd_setpt(pd_setpt),
    .bias_ana_hi(bias_ana_hi), .pd_ana_hi(pd_ana_hi), .dac_drop(dac_drop),
    .flt_now(flt_now)
  );

  lbg_recovery #(.HOLD_CYC(HOLD_CYC), .NEG_CYC(NEG_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n), .flt_now(flt_now), .rel_req(rel_req),
    .latched(latched), .drv_off(drv_off), .sticky(sticky)
  );

  always_comb begin
    rel_req      = dis_pin | ~bias_en;
    bias_gate    = bias_en & ~dis_pin & ~drv_off;
    flt_pin      = latched;
    stat_fault   = sticky;
    stat_drv_off = drv_off;
  end

  assert_gate_off_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pin |-> !bias_gate);
  assert_dis_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dis_pin |-> !bias_gate);
  assert_resume_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flt_pin) && stat_drv_off) |-> !bias_gate);
endmodule

// File: tb/sim_lbias_guard.sv
module sim_lbias_guard;
  localparam int HOLD = 8;
  localparam int NEG  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, bias_en = 0, dis_pin = 0, dig_bias_mode = 0, dig_pd_mode = 0, pd_trig_en = 0;
  logic [7:0] bias_thr = 0, pd_thr = 0;
  logic [9:0] bias_meas = 0, pd_meas = 0, pd_setpt = 0, dac_code = 0;
  logic dac_load = 0, bias_ana_hi = 0, pd_ana_hi = 0;
  logic bias_gate, flt_pin, stat_fault, stat_drv_off;

  always #4 clk = ~clk;

  lbias_guard #(.HOLD_CYC(HOLD), .NEG_CYC(NEG)) u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference: phase 0 run, 1 latched, 2 releasing, 3 waiting to resume
  int ph = 0, cnt = 0, prev = 0;
  bit sticky = 0;

  function automatic bit fault_cond();
    bit f = 0;
    if (dig_bias_mode) f |= (int'(bias_meas) / 4) > int'(bias_thr);
    else f |= bias_ana_hi;
    if (dig_pd_mode) f |= (int'(pd_meas) / 4) > int'(pd_thr);
    else f |= pd_trig_en && pd_ana_hi;
    f |= 2 * int'(pd_meas) > 3 * int'(pd_setpt);
    f |= dac_load && (2 * int'(dac_code) < prev);
    return arm && f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; prev = 0; sticky = 0;
    end else begin
      bit f, rel;
      f = fault_cond();
      rel = dis_pin || !bias_en;
      case (ph)
        0: if (f) begin ph = 1; sticky = 1; end
        1: if (rel) begin ph = 2; cnt = 1; end
        2: if (rel) cnt = cnt + 1;
           else if (cnt < HOLD || f) ph = 1;
           else begin ph = 3; cnt = 1; end
        default: if (f) ph = 1;
                 else if (cnt >= NEG) begin ph = 0; sticky = 0; end
                 else cnt = cnt + 1;
      endcase
      if (dac_load) prev = int'(dac_code);
    end
  end

  task automatic compare();
    bit eg, ef, es, ed;
    eg = bias_en && !dis_pin && ph == 0;
    ef = (ph == 1);
    es = sticky;
    ed = (ph != 0);
    checks++;
    if ({bias_gate, flt_pin, stat_fault, stat_drv_off} !== {eg, ef, es, ed}) begin
      fails++;
      $display("FAIL %s cycle %0d: gate/pin/fault/drvoff actual %b%b%b%b expected %b%b%b%b",
               cur_req, cyc, bias_gate, flt_pin, stat_fault, stat_drv_off, eg, ef, es, ed);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic expect_pin(bit v, string tag);
    checks++;
    if (flt_pin !== v) begin
      fails++;
      $display("FAIL %s: flt_pin actual %b expected %b", tag, flt_pin, v);
    end
  endtask

  task automatic release_for(int n, bit use_dis);
    if (use_dis) dis_pin = 1; else bias_en = 0;
    step(n);
    dis_pin = 0; bias_en = 1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; bias_en = 1; pd_setpt = 10'd500;
    step(3);
    cur_req = "R2"; bias_ana_hi = 1; pd_ana_hi = 1; pd_trig_en = 1;
    step(4); expect_pin(0, "R2");
    bias_ana_hi = 0; pd_ana_hi = 0; pd_trig_en = 0; arm = 1;
    step(2);
    cur_req = "R3"; dig_bias_mode = 1; bias_thr = 8'h40; bias_meas = 10'h100;
    step(3); expect_pin(0, "R3 equal");
    bias_meas = 10'h104;
    step(1); expect_pin(1, "R7 latch");
    cur_req = "R7"; step(3);
    bias_meas = 0;
    cur_req = "R9"; release_for(HOLD + 2, 1);
    step(NEG + 4);
    cur_req = "R3"; dig_bias_mode = 0; bias_ana_hi = 1;
    step(2); expect_pin(1, "R3 analog");
    bias_ana_hi = 0;
    release_for(HOLD, 1); step(NEG + 3);
    cur_req = "R4"; pd_ana_hi = 1;
    step(3); expect_pin(0, "R4 untriggered");
    pd_trig_en = 1;
    step(2); expect_pin(1, "R4 triggered");
    cur_req = "R8"; release_for(3, 0);
    step(3); expect_pin(1, "R8 short");
    cur_req = "R10"; release_for(HOLD + 1, 0);
    step(3); expect_pin(1, "R10 persist");
    pd_ana_hi = 0; pd_trig_en = 0;
    cur_req = "R9"; release_for(HOLD + 1, 0); step(NEG + 3);
    cur_req = "R4"; dig_pd_mode = 1; pd_thr = 8'h20; pd_meas = 10'h080;
    step(3); expect_pin(0, "R4 equal");
    pd_meas = 10'h084;
    step(2); expect_pin(1, "R4 digital");
    pd_meas = 0; dig_pd_mode = 0;
    release_for(HOLD, 1); step(NEG + 3);
    cur_req = "R5"; pd_setpt = 10'd200; pd_meas = 10'd300;
    step(3); expect_pin(0, "R5 equal");
    pd_meas = 10'd301;
    step(2); expect_pin(1, "R5 over");
    pd_meas = 0;
    release_for(HOLD, 1); step(NEG + 3);
    cur_req = "R6"; dac_code = 10'd400; dac_load = 1; step(1); dac_load = 0; step(1);
    dac_code = 10'd200; dac_load = 1; step(1); dac_load = 0;
    step(2); expect_pin(0, "R6 half");
    dac_code = 10'd99; dac_load = 1; step(1); dac_load = 0;
    step(1); expect_pin(1, "R6 drop");
    release_for(HOLD, 1); step(NEG + 3);
    cur_req = "R11"; dis_pin = 1; step(3); dis_pin = 0; step(3);
    finish_up();
  end
endmodule